// File: doc/BRIEF.md
# Extended Control Field Lock Register File

This block holds the extended control fields of a UART that share byte addresses with the classic 16550-style registers: the upper half of the interrupt-enable byte, two bits of the interrupt-status control byte, two bits of the FIFO control byte and the top three bits of the modem control byte. A separate unlock bit in a configuration register decides whether host writes may change those fields. While the unlock bit is clear, the fields hold their values, so older driver code that rewrites the shared bytes cannot disturb an extended setup. The bits that are not protected stay writable at all times.

The host reaches the block over a plain register bus with an address, write data, a write strobe and registered read data. The latched bytes and the unlock bit drive the rest of the UART directly from flip-flops. Reset is synchronous and active high.

Top module: `xreg_protect`

## Requirements
- R1: A reset clears all four control bytes, the unlock bit and the read data to 0.
- R2: The unlock bit is bit 4 of the configuration register at address 4. It takes its value from a write there, and it reads back in bit 4 with every other bit of that register reading 0.
- R3: While the unlock bit is 1, a write stores the protected fields from the write data. The protected fields are bits 7:4 at address 0 (interrupt enable), bits 5:4 at address 1 (interrupt-status control), bits 5:4 at address 2 (FIFO control) and bits 7:5 at address 3 (modem control).
- R4: While the unlock bit is 0, a write leaves the protected fields of the addressed byte at their previous values.
- R5: The unprotected bits of each byte at addresses 0 to 3 take the write data on every write, whatever the value of the unlock bit.
- R6: A write to the unlock bit governs the writes that come after it. The first write in the next cycle already sees the new value.
- R7: Read data is registered. One cycle after an address is presented, it shows the full latched byte at that address, and addresses 5 to 7 read 0.
- R8: A write changes only the register at its own address. Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 8 | Registered read data |
| ext_unlock | output | 1 | Current unlock bit |
| ien_q | output | 8 | Latched interrupt-enable byte |
| isc_q | output | 8 | Latched interrupt-status control byte |
| fctl_q | output | 8 | Latched FIFO control byte |
| mctl_q | output | 8 | Latched modem control byte |

## Verification
If the unlock bit is wrong, the next write to a shared byte either changes a frozen field or fails to change an unlocked one. Because every byte is driven straight from its flip-flops, that shows up on the output ports at the clock edge that takes the write. It shows up on the read data one cycle later. A wrong protection mask is visible in the same way, as a byte whose unprotected bits refuse the write data, or whose protected bits follow it while the block is locked. Mis-decoded addresses show up as changes in a byte that was never addressed.

// File: rtl/xreg_pkg.sv
package xreg_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int NUM_REG = 4;
  localparam int UNLOCK_BIT = 4;

  typedef logic [DATA_W-1:0] word_t;

  localparam logic [ADDR_W-1:0] A_IEN  = 3'd0;
  localparam logic [ADDR_W-1:0] A_ISC  = 3'd1;
  localparam logic [ADDR_W-1:0] A_FCTL = 3'd2;
  localparam logic [ADDR_W-1:0] A_MCTL = 3'd3;
  localparam logic [ADDR_W-1:0] A_CFG  = 3'd4;

  // Protected bit positions per byte; the UART core decodes these positions.
  function automatic word_t prot_mask(input int idx);
    case (idx)
      0:       return 8'hF0;
      1:       return 8'h30;
      2:       return 8'h30;
      3:       return 8'hE0;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/xreg_guard_field.sv
module xreg_guard_field #(
  parameter int              W    = 8,
  parameter logic [W-1:0]    PROT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         unlock,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] nxt;

  // Free bits follow the data; guarded bits follow it only when unlocked.
  always_comb begin
    nxt = (wdata & ~PROT) | ((unlock ? wdata : q) & PROT);
  end

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= nxt;
  end
endmodule

// File: rtl/xreg_unlock_ctl.sv
module xreg_unlock_ctl (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wbit,
  output logic unlock
);
  always_ff @(posedge clk) begin
    if (rst)        unlock <= 1'b0;
    else if (wr_en) unlock <= wbit;
  end
endmodule

// File: rtl/xreg_readback.sv
module xreg_readback #(
  parameter int                NREG     = 4,
  parameter int                AW       = 3,
  parameter int                DW       = 8,
  parameter logic [AW-1:0]     CFG_ADDR = '0,
  parameter int                EN_BIT   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [AW-1:0]            addr,
  input  logic [NREG-1:0][DW-1:0]  regs,
  input  logic                     unlock,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mux;

  always_comb begin
    mux = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr == AW'(i)) mux = regs[i];
    end
    if (addr == CFG_ADDR) mux[EN_BIT] = unlock;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mux;
  end
endmodule

// File: rtl/xreg_protect.sv
module xreg_protect
  import xreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              ext_unlock,
  output logic [DATA_W-1:0] ien_q,
  output logic [DATA_W-1:0] isc_q,
  output logic [DATA_W-1:0] fctl_q,
  output logic [DATA_W-1:0] mctl_q
);
  logic [NUM_REG-1:0][DATA_W-1:0] bank;
  logic                           cfg_wr;

  assign cfg_wr = reg_we && (reg_addr == A_CFG);

  xreg_unlock_ctl u_unlock (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_wr),
    .wbit   (reg_wdata[UNLOCK_BIT]),
    .unlock (ext_unlock)
  );

  for (genvar g = 0; g < NUM_REG; g++) begin : g_field
    logic sel;
    assign sel = reg_we && (reg_addr == ADDR_W'(g));
    xreg_guard_field #(
      .W    (DATA_W),
      .PROT (prot_mask(g))
    ) u_field (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (sel),
      .unlock (ext_unlock),
      .wdata  (reg_wdata),
      .q      (bank[g])
    );
  end

  xreg_readback #(
    .NREG     (NUM_REG),
    .AW       (ADDR_W),
    .DW       (DATA_W),
    .CFG_ADDR (A_CFG),
    .EN_BIT   (UNLOCK_BIT)
  ) u_rd (
    .clk    (clk),
    .rst    (rst),
    .addr   (reg_addr),
    .regs   (bank),
    .unlock (ext_unlock),
    .rdata  (reg_rdata)
  );

  assign ien_q  = bank[0];
  assign isc_q  = bank[1];
  assign fctl_q = bank[2];
  assign mctl_q = bank[3];
endmodule

// File: rtl/xreg_protect_chk.sv
module xreg_protect_chk
  import xreg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              ext_unlock,
  input logic [DATA_W-1:0] ien_q,
  input logic [DATA_W-1:0] isc_q,
  input logic [DATA_W-1:0] fctl_q,
  input logic [DATA_W-1:0] mctl_q
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (ext_unlock == 1'b0 && ien_q == '0 && isc_q == '0 &&
             fctl_q == '0 && mctl_q == '0 && reg_rdata == '0));

  assert_unlock_write_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_CFG) |=> ext_unlock == $past(reg_wdata[UNLOCK_BIT]));

  assert_open_store_R3: assert property (@(posedge clk) disable iff (rst)
    (reg_we && ext_unlock && reg_addr == A_MCTL) |=> mctl_q[7:5] == $past(reg_wdata[7:5]));

  assert_locked_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !ext_unlock && reg_addr == A_IEN) |=> ien_q[7:4] == $past(ien_q[7:4]));

  assert_locked_hold_fctl_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !ext_unlock && reg_addr == A_FCTL) |=> fctl_q[5:4] == $past(fctl_q[5:4]));

  assert_free_bits_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == A_IEN) |=> ien_q[3:0] == $past(reg_wdata[3:0]));

  assert_readback_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == A_ISC) |=> reg_rdata == $past(isc_q));

  assert_isolation_R8: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_addr == A_IEN) |=> $stable(ien_q));
endmodule

bind xreg_protect xreg_protect_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_we     (reg_we),
  .reg_rdata  (reg_rdata),
  .ext_unlock (ext_unlock),
  .ien_q      (ien_q),
  .isc_q      (isc_q),
  .fctl_q     (fctl_q),
  .mctl_q     (mctl_q)
);

// File: tb/xreg_protect_tb.sv
module xreg_protect_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic       ext_unlock;
  logic [7:0] ien_q, isc_q, fctl_q, mctl_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  xreg_protect dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .ext_unlock(ext_unlock),
    .ien_q(ien_q), .isc_q(isc_q), .fctl_q(fctl_q), .mctl_q(mctl_q)
  );

  // {write addr, write data, read addr, expected read, requirement tag}
  typedef struct packed {
    logic [2:0]  wa;
    logic [7:0]  wd;
    logic [2:0]  ra;
    logic [7:0]  exp;
    logic [15:0] tag;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{3'd4, 8'h10, 3'd4, 8'h10, "R2"},
    '{3'd0, 8'hFF, 3'd0, 8'hFF, "R3"},
    '{3'd1, 8'hFF, 3'd1, 8'hFF, "R3"},
    '{3'd2, 8'h3C, 3'd2, 8'h3C, "R3"},
    '{3'd3, 8'hE3, 3'd3, 8'hE3, "R3"},
    '{3'd4, 8'h00, 3'd4, 8'h00, "R2"},
    '{3'd0, 8'h05, 3'd0, 8'hF5, "R4"},
    '{3'd1, 8'h00, 3'd1, 8'h30, "R4"},
    '{3'd2, 8'hC3, 3'd2, 8'hF3, "R5"},
    '{3'd3, 8'h1C, 3'd3, 8'hFC, "R5"},
    '{3'd4, 8'hFF, 3'd4, 8'h10, "R2"},
    '{3'd0, 8'h5A, 3'd0, 8'h5A, "R6"},
    '{3'd3, 8'h00, 3'd3, 8'h00, "R3"},
    '{3'd4, 8'hEF, 3'd4, 8'h00, "R2"},
    '{3'd3, 8'hFF, 3'd3, 8'h1F, "R6"},
    '{3'd5, 8'hFF, 3'd0, 8'h5A, "R8"},
    '{3'd6, 8'hFF, 3'd6, 8'h00, "R7"}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b0;
    @(negedge clk);
    v = reg_rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state at ports and through readback
    check("R1 unlock", {7'd0, ext_unlock}, 8'h00);
    check("R1 ien", ien_q, 8'h00);
    check("R1 mctl", mctl_q, 8'h00);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check("R1 readback", v, 8'h00);
    end
    // R4: locked after reset, protected bits of a fresh write are dropped
    wr(3'd2, 8'hFF);
    check("R4 fctl locked from reset", fctl_q, 8'hCF);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].wa, VEC[i].wd);
      rd(VEC[i].ra, v);
      check(string'(VEC[i].tag), v, VEC[i].exp);
    end

    // Port view after the table; R8 unmapped writes left everything alone
    check("R8 ien port", ien_q, 8'h5A);
    check("R8 isc port", isc_q, 8'h30);
    check("R8 fctl port", fctl_q, 8'hF3);
    check("R8 mctl port", mctl_q, 8'h1F);

    // R6: unlock then protected write on the very next cycle
    @(negedge clk);
    reg_addr = 3'd4; reg_wdata = 8'h10; reg_we = 1'b1;
    @(negedge clk);
    reg_addr = 3'd1; reg_wdata = 8'h00;
    @(negedge clk);
    reg_we = 1'b0;
    check("R6 isc back-to-back", isc_q, 8'h00);
    // R7: readback lags the address by one cycle
    @(negedge clk);
    reg_addr = 3'd0;
    @(negedge clk);
    reg_addr = 3'd3;
    check("R7 lag ien", reg_rdata, 8'h5A);
    @(negedge clk);
    check("R7 lag mctl", reg_rdata, 8'h1F);

    // R1: reset in the middle of operation
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid unlock", {7'd0, ext_unlock}, 8'h00);
    check("R1 mid ien", ien_q, 8'h00);
    check("R1 mid fctl", fctl_q, 8'h00);
    check("R1 mid rdata", reg_rdata, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule